// File: doc/BRIEF.md
# Register-Pair 64-bit Shifter

This execution unit gives a 32-bit core double-word logical shifts. A 64-bit operand lives in two consecutive general registers. The register named by the instruction holds the upper word, and the next register, wrapping from 31 to 0, holds the lower word. The unit decodes the instruction word itself and reports the three register indices it reads. The register file then supplies the two operand words and the shift-amount register value. One clock later the unit returns both result words, the destination pair indices, a write strobe, an optional condition-field update and an illegal-operand flag.

The shift count is the low six bits of the amount register. The next bit up clears the whole result. Higher bits are ignored. Only some register numbers may name a pair, and only some may hold the shift amount. If an instruction names any other register, it is rejected as illegal. A rejected instruction writes no register and no condition field.

Top module: `rps_shifter`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Reset clears `out_valid`, `wb_en`, `cr0_we` and `illegal`.
- R2: The unit claims an instruction only when `insn[31:26]` is 31 and `insn[10:1]` is `0000111011` (left) or `1000111011` (right). An unclaimed word gives `wb_en`=0, `cr0_we`=0 and `illegal`=0.
- R3: For a claimed word, the source pair field `insn[25:21]` and the destination pair field `insn[20:16]` must be set bits of mask 0xF00003FF. The amount field `insn[15:11]` must be a set bit of mask 0xF00027FF. If any field fails, `illegal`=1, `wb_en`=0 and `cr0_we`=0. Otherwise `wb_en`=1.
- R4: The operand is {`src_hi`,`src_lo`}. `res_hi` carries result bits 63:32 and `res_lo` carries bits 31:0. `wb_hi_idx` equals the destination field.
- R5: When bit 6 of `amt_val` is set, both result words are zero.
- R6: For the left encoding, the operand shifts left by `amt_val[5:0]` and zeros fill the vacated low bits.
- R7: For the right encoding, the operand shifts right by `amt_val[5:0]` and zeros fill the vacated high bits.
- R8: Bits 31:7 of `amt_val` have no effect on the result.
- R9: When `insn[0]` is 1 on a legal instruction, `cr0_we`=1 and `cr0`={LT,GT,EQ,SO}, with LT in bit 3. Exactly one of LT, GT and EQ is set, from a signed compare of the 64-bit result with zero. SO equals `so_in`.
- R10: When `insn[0]` is 0, `cr0_we` stays 0.
- R11: A lower-word index is the upper index plus one, modulo 32. This holds for `rd_src_lo_idx` and `wb_lo_idx`, so index 31 pairs with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands valid this cycle |
| insn | input | 32 | Instruction word |
| src_hi | input | 32 | Upper word of the source pair |
| src_lo | input | 32 | Lower word of the source pair |
| amt_val | input | 32 | Shift-amount register value |
| so_in | input | 1 | Summary-overflow bit from the fixed-point status register |
| rd_src_hi_idx | output | 5 | Read index, upper source word (combinational) |
| rd_src_lo_idx | output | 5 | Read index, lower source word (combinational) |
| rd_amt_idx | output | 5 | Read index, shift-amount register (combinational) |
| out_valid | output | 1 | Result cycle |
| wb_en | output | 1 | Write the result pair |
| wb_hi_idx | output | 5 | Destination index, upper word |
| wb_lo_idx | output | 5 | Destination index, lower word |
| res_hi | output | 32 | Result bits 63:32 |
| res_lo | output | 32 | Result bits 31:0 |
| cr0_we | output | 1 | Write condition field 0 |
| cr0 | output | 4 | {LT,GT,EQ,SO} |
| illegal | output | 1 | Claimed instruction names a forbidden register |

## Verification
The read indices are combinational, so they are checked in the same cycle the instruction word is applied. Every other output is due one rising edge after the cycle in which `in_valid` is sampled high. The bench drives each instruction at a falling edge and holds it for one full period. It then reads results at the next falling edge, which lies half a period past the capturing edge and clear of any update. After that it inserts an idle cycle to confirm `out_valid` drops.

// File: rtl/rps_pkg.sv
package rps_pkg;

    localparam int INSN_W      = 32;
    localparam int REG_FIELD_W = 5;
    localparam int NUM_REGS    = 1 << REG_FIELD_W;
    localparam int OPC_W       = 6;
    localparam int XO_W        = 10;

    localparam logic [OPC_W-1:0] OPC_EXTENDED = 6'd31;
    localparam logic [XO_W-1:0]  XO_SHIFT_L   = 10'b0000111011;
    localparam logic [XO_W-1:0]  XO_SHIFT_R   = 10'b1000111011;

    typedef logic [REG_FIELD_W-1:0] reg_idx_t;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic       hit;
        shift_dir_e dir;
        logic       rc;
        reg_idx_t   src;
        reg_idx_t   dst;
        reg_idx_t   amt;
    } dec_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_field_t;

    function automatic logic map_has(input logic [NUM_REGS-1:0] map, input reg_idx_t idx);
        return map[idx];
    endfunction

    function automatic reg_idx_t pair_partner(input reg_idx_t idx);
        return idx + reg_idx_t'(1);
    endfunction

endpackage

// File: rtl/rps_decode.sv
module rps_decode
    import rps_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] PAIR_MAP = 32'hF00003FF,
    parameter logic [NUM_REGS-1:0] AMT_MAP  = 32'hF00027FF
) (
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec,
    output logic              legal
);
    logic [OPC_W-1:0] opc;
    logic [XO_W-1:0]  xo;
    logic             is_l;
    logic             is_r;

    always_comb begin
        opc  = insn[31:26];
        xo   = insn[10:1];
        is_l = (xo == XO_SHIFT_L);
        is_r = (xo == XO_SHIFT_R);
        dec.hit = (opc == OPC_EXTENDED) && (is_l || is_r);
        dec.dir = is_r ? DIR_RIGHT : DIR_LEFT;
        dec.rc  = insn[0];
        dec.src = insn[25:21];
        dec.dst = insn[20:16];
        dec.amt = insn[15:11];
        legal   = map_has(PAIR_MAP, dec.src) &&
                  map_has(PAIR_MAP, dec.dst) &&
                  map_has(AMT_MAP,  dec.amt);
    end
endmodule

// File: rtl/rps_barrel.sv
module rps_barrel #(
    parameter int DW   = 64,
    parameter int SH_W = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    input  logic [SH_W:0] amt,
    input  logic          right,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stg [SH_W+1];

    assign stg[0] = din;

    for (genvar g = 0; g < SH_W; g++) begin : g_stage
        localparam int STEP = 1 << g;
        assign stg[g+1] = !amt[g] ? stg[g] :
                          right   ? (stg[g] >> STEP) : (stg[g] << STEP);
    end

    // the bit just above the count field clears everything
    assign dout = amt[SH_W] ? '0 : stg[SH_W];
endmodule

// File: rtl/rps_crgen.sv
module rps_crgen
    import rps_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] val,
    input  logic          so,
    output cr_field_t     cr
);
    always_comb begin
        cr.lt = val[DW-1];
        cr.eq = (val == '0);
        cr.gt = !cr.lt && !cr.eq;
        cr.so = so;
    end
endmodule

// File: rtl/rps_shifter.sv
module rps_shifter
    import rps_pkg::*;
#(
    parameter int                  WORD_W   = 32,
    parameter logic [NUM_REGS-1:0] PAIR_MAP = 32'hF00003FF,
    parameter logic [NUM_REGS-1:0] AMT_MAP  = 32'hF00027FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic [WORD_W-1:0] src_hi,
    input  logic [WORD_W-1:0] src_lo,
    input  logic [WORD_W-1:0] amt_val,
    input  logic              so_in,
    output logic [4:0]        rd_src_hi_idx,
    output logic [4:0]        rd_src_lo_idx,
    output logic [4:0]        rd_amt_idx,
    output logic              out_valid,
    output logic              wb_en,
    output logic [4:0]        wb_hi_idx,
    output logic [4:0]        wb_lo_idx,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo,
    output logic              cr0_we,
    output logic [3:0]        cr0,
    output logic              illegal
);
    localparam int DW   = 2 * WORD_W;
    localparam int SH_W = $clog2(DW);

    dec_t          dec;
    logic          legal;
    logic          accept;
    logic [DW-1:0] shifted;
    cr_field_t     cr_next;
    logic          unused_amt_hi;

    assign unused_amt_hi = ^amt_val[WORD_W-1:SH_W+1];

    rps_decode #(.PAIR_MAP(PAIR_MAP), .AMT_MAP(AMT_MAP)) u_dec (
        .insn  (insn),
        .dec   (dec),
        .legal (legal)
    );

    rps_barrel #(.DW(DW), .SH_W(SH_W)) u_sh (
        .din   ({src_hi, src_lo}),
        .amt   (amt_val[SH_W:0]),
        .right (dec.dir == DIR_RIGHT),
        .dout  (shifted)
    );

    rps_crgen #(.DW(DW)) u_cr (
        .val (shifted),
        .so  (so_in),
        .cr  (cr_next)
    );

    assign accept        = dec.hit && legal;
    assign rd_src_hi_idx = dec.src;
    assign rd_src_lo_idx = pair_partner(dec.src);
    assign rd_amt_idx    = dec.amt;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            cr0_we    <= 1'b0;
            illegal   <= 1'b0;
            res_hi    <= '0;
            res_lo    <= '0;
            wb_hi_idx <= '0;
            wb_lo_idx <= '0;
            cr0       <= '0;
        end else begin
            out_valid <= in_valid;
            wb_en     <= in_valid && accept;
            cr0_we    <= in_valid && accept && dec.rc;
            illegal   <= in_valid && dec.hit && !legal;
            if (in_valid) begin
                res_hi    <= accept ? shifted[DW-1:WORD_W] : '0;
                res_lo    <= accept ? shifted[WORD_W-1:0]  : '0;
                wb_hi_idx <= dec.dst;
                wb_lo_idx <= pair_partner(dec.dst);
                cr0       <= (accept && dec.rc) ? cr_next : '0;
            end
        end
    end

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_origin_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
    p_strobes_need_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (wb_en || cr0_we || illegal) |-> out_valid);
    p_illegal_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wb_en && !cr0_we));
    p_kill_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && accept && amt_val[SH_W]) |=> (res_hi == '0 && res_lo == '0));
    p_cr_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        cr0_we |-> ($countones(cr0[3:1]) == 1));
    p_no_rc_no_cr_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !insn[0]) |=> !cr0_we);
endmodule

// File: tb/sim_rps_shifter.sv
`timescale 1ns/1ps
module sim_rps_shifter;

    localparam logic [9:0] XL = 10'b0000111011;
    localparam logic [9:0] XR = 10'b1000111011;

    typedef struct packed {
        logic        dir;
        logic        rc;
        logic        so;
        logic [31:0] amt;
        logic [63:0] op;
        logic [63:0] exp;
        logic [3:0]  cr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b0, 32'd4,        64'h0000000000000001, 64'h0000000000000010, 4'b0100},
        '{1'b1, 1'b1, 1'b1, 32'd8,        64'h123456789ABCDEF0, 64'h00123456789ABCDE, 4'b0101},
        '{1'b0, 1'b1, 1'b0, 32'd63,       64'h0000000000000001, 64'h8000000000000000, 4'b1000},
        '{1'b1, 1'b0, 1'b0, 32'd63,       64'h8000000000000000, 64'h0000000000000001, 4'b0000},
        '{1'b0, 1'b1, 1'b0, 32'h40,       64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 4'b0010},
        '{1'b1, 1'b1, 1'b1, 32'h7F,       64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 4'b0011},
        '{1'b0, 1'b1, 1'b0, 32'hFFFFFF84, 64'h0000000FF0000000, 64'h000000FF00000000, 4'b0100},
        '{1'b0, 1'b1, 1'b0, 32'd32,       64'h00000000DEADBEEF, 64'hDEADBEEF00000000, 4'b1000},
        '{1'b1, 1'b1, 1'b0, 32'd0,        64'hCAFEF00D12345678, 64'hCAFEF00D12345678, 4'b1000},
        '{1'b1, 1'b1, 1'b0, 32'd36,       64'hF000000000000000, 64'h000000000F000000, 4'b0100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] src_hi = '0;
    logic [31:0] src_lo = '0;
    logic [31:0] amt_val = '0;
    logic        so_in = 1'b0;
    logic [4:0]  rd_src_hi_idx, rd_src_lo_idx, rd_amt_idx;
    logic        out_valid, wb_en, cr0_we, illegal;
    logic [4:0]  wb_hi_idx, wb_lo_idx;
    logic [31:0] res_hi, res_lo;
    logic [3:0]  cr0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rps_shifter u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .src_hi(src_hi), .src_lo(src_lo), .amt_val(amt_val), .so_in(so_in),
        .rd_src_hi_idx(rd_src_hi_idx), .rd_src_lo_idx(rd_src_lo_idx),
        .rd_amt_idx(rd_amt_idx), .out_valid(out_valid), .wb_en(wb_en),
        .wb_hi_idx(wb_hi_idx), .wb_lo_idx(wb_lo_idx), .res_hi(res_hi),
        .res_lo(res_lo), .cr0_we(cr0_we), .cr0(cr0), .illegal(illegal)
    );

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] s,
                                       input logic [4:0] d, input logic [4:0] a,
                                       input logic [9:0] xo, input logic rc);
        return {opc, s, d, a, xo, rc};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, capture at the next rising edge, read at the next falling edge
    task automatic issue(input logic [31:0] w, input logic [63:0] op,
                         input logic [31:0] a, input logic so);
        @(negedge clk);
        insn = w; src_hi = op[63:32]; src_lo = op[31:0]; amt_val = a; so_in = so;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1: watchdog expired, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset out_valid", 64'(out_valid), 64'd0);
        chk("R1 reset wb_en", 64'(wb_en), 64'd0);
        chk("R1 reset illegal", 64'(illegal), 64'd0);
        chk("R1 reset cr0_we", 64'(cr0_we), 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = (i == 4 || i == 5) ? "R5" : (i == 6) ? "R8" : VEC[i].dir ? "R7" : "R6";
            issue(mk(6'd31, 5'd3, 5'd5, 5'd10, VEC[i].dir ? XR : XL, VEC[i].rc),
                  VEC[i].op, VEC[i].amt, VEC[i].so);
            chk("R1 out_valid", 64'(out_valid), 64'd1);
            chk("R3 wb_en", 64'(wb_en), 64'd1);
            chk(tag, {res_hi, res_lo}, VEC[i].exp);
            chk("R10 cr0_we", 64'(cr0_we), 64'(VEC[i].rc));
            if (VEC[i].rc) chk("R9 cr0", 64'(cr0), 64'(VEC[i].cr));
            chk("R4 wb_hi_idx", 64'(wb_hi_idx), 64'd5);
            chk("R11 wb_lo_idx", 64'(wb_lo_idx), 64'd6);
        end

        // R1 idle cycle drops out_valid
        @(negedge clk);
        chk("R1 idle", 64'(out_valid), 64'd0);

        // R11 read index wrap, combinational
        @(negedge clk);
        insn = mk(6'd31, 5'd31, 5'd0, 5'd13, XL, 1'b0);
        #1;
        chk("R11 rd_src_hi_idx", 64'(rd_src_hi_idx), 64'd31);
        chk("R11 rd_src_lo_idx", 64'(rd_src_lo_idx), 64'd0);
        chk("R11 rd_amt_idx", 64'(rd_amt_idx), 64'd13);

        // R3 forbidden source pair
        issue(mk(6'd31, 5'd12, 5'd5, 5'd10, XL, 1'b1), 64'h1, 32'd1, 1'b0);
        chk("R3 src illegal", 64'(illegal), 64'd1);
        chk("R3 src wb_en", 64'(wb_en), 64'd0);
        chk("R3 src cr0_we", 64'(cr0_we), 64'd0);
        // R3 forbidden destination pair
        issue(mk(6'd31, 5'd3, 5'd20, 5'd10, XR, 1'b0), 64'h1, 32'd1, 1'b0);
        chk("R3 dst illegal", 64'(illegal), 64'd1);
        chk("R3 dst wb_en", 64'(wb_en), 64'd0);
        // R3 forbidden amount register 11, allowed 13
        issue(mk(6'd31, 5'd3, 5'd5, 5'd11, XL, 1'b0), 64'h1, 32'd1, 1'b0);
        chk("R3 amt11 illegal", 64'(illegal), 64'd1);
        issue(mk(6'd31, 5'd3, 5'd5, 5'd13, XL, 1'b0), 64'h1, 32'd1, 1'b0);
        chk("R3 amt13 illegal", 64'(illegal), 64'd0);
        chk("R3 amt13 wb_en", 64'(wb_en), 64'd1);
        chk("R6 amt13 result", {res_hi, res_lo}, 64'h2);

        // R11 destination pair 31 wraps to 0
        issue(mk(6'd31, 5'd28, 5'd31, 5'd0, XR, 1'b0), 64'h100, 32'd4, 1'b0);
        chk("R11 wb_hi_idx", 64'(wb_hi_idx), 64'd31);
        chk("R11 wb_lo_idx", 64'(wb_lo_idx), 64'd0);
        chk("R7 wrap result", {res_hi, res_lo}, 64'h10);

        // R2 foreign primary opcode, even with forbidden registers
        issue(mk(6'd30, 5'd12, 5'd20, 5'd11, XL, 1'b1), 64'h1, 32'd1, 1'b0);
        chk("R2 opc out_valid", 64'(out_valid), 64'd1);
        chk("R2 opc wb_en", 64'(wb_en), 64'd0);
        chk("R2 opc illegal", 64'(illegal), 64'd0);
        chk("R2 opc cr0_we", 64'(cr0_we), 64'd0);
        // R2 foreign extended opcode
        issue(mk(6'd31, 5'd3, 5'd5, 5'd10, 10'b0000111010, 1'b1), 64'h1, 32'd1, 1'b0);
        chk("R2 xo wb_en", 64'(wb_en), 64'd0);
        chk("R2 xo illegal", 64'(illegal), 64'd0);
        chk("R2 xo cr0_we", 64'(cr0_we), 64'd0);

        finish_run();
    end
endmodule